// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs bus cycles for a processor on a shared address/data bus in a minimum-mode system. An internal client presents one transfer at a time: memory or I/O, read or write, byte or word, and a 20-bit address. The sequencer walks the bus through the states T1, T2, T3, any wait states and T4. It drives the address, the address latch strobe, the read and write strobes, the transceiver enable and direction, the memory/I/O select and the byte-lane enables. It captures read data and reports each finished transfer with a one-clock pulse.

Half-clock events are modelled with `clk` running at twice the bus-state rate. Each T-state therefore spans two `clk` periods: a first half and a second half. Another master can take the bus with `hold`. The block grants it with `hlda`, but only at the midpoint of T4 or of an idle state. While the grant lasts, the address/data and control outputs are released through their enables. A word at an odd address is split into two byte cycles, and the two bytes are joined again before the client sees them.

Top module: `bus_cycle_seq`

## Requirements
- R1: T1, T2, T3 and T4 each last two `clk` periods. From the first clock with `ale` high to the clock with `done` high, the span is 7 + 2·W clocks inclusive, where W is the number of wait states.
- R2: `ale` is high for exactly the two clocks of T1 in each bus cycle and low at every other time, including during a hold grant. It has no enable and is never released.
- R3: `rdy` is sampled on the rising edge that ends T3 and on the edge that ends each wait state. A low sample inserts one more wait state of two clocks.
- R4: `rd_n` is low during T2, T3 and the wait states of a read, and `wr_n` is low during the same states of a write. That is 4 + 2·W clocks per bus cycle, and the two strobes are never low together.
- R5: For a read, `den_n` is low from the second half of T2 through the first half of T4 (4 + 2·W clocks). For a write, it is low from the start of T2 through the first half of T4 (5 + 2·W clocks).
- R6: `mio` (1 = memory, 0 = I/O) and `dtr` (1 = transmit/write, 0 = receive/read) take a cycle's values at the midpoint of the T4 or idle state before its T1. They stay constant until that cycle has finished.
- R7: During T1, `ad_out` carries address bits 15..0. The pair (`bhe_n`, `ad_out[0]`) is 00 for a word, 01 for a byte on the upper lane at an odd address, and 10 for a byte on the lower lane at an even address.
- R8: In an I/O cycle, `a_hi_out` is zero during T1, and address bits above bit 15 of the request are dropped.
- R9: When `hold` is high at the midpoint of T4 or of an idle state, `hlda` rises at that edge. `bus_oe` and `ad_oe` are low while `hlda` is high, no request is accepted and no bus cycle starts. `hlda` falls at the first edge that samples `hold` low.
- R10: A word at odd address A runs as two bus cycles. The first is at A with `bhe_n`=0 and the low byte on the upper lane. The second is at A+1 with `bhe_n`=1 and the high byte on the lower lane. A single `done` pulse follows the second cycle.
- R11: While reset is active, and right after it ends, `ale`, `hlda`, `ad_oe`, `bus_oe` and `done` are 0, `rd_n` and `wr_n` are 1, and the sequencer is idle.
- R12: Read data is taken from `ad_in` on the edge where `rdy` is sampled high. `rdata` holds the word, or the byte from the lane selected by A0 zero-extended. `done` is high for one clock at the start of T4.
- R13: In a write, `ad_oe` is high from T1 through T4. A word is placed across both lanes, and a byte value is repeated on both lanes. In a read, `ad_oe` is low from T2 through T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Client transfer request |
| req_ready | output | 1 | Request is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | 20 | Transfer byte address |
| req_wdata | input | 16 | Write data; byte transfers use bits 7..0 |
| done | output | 1 | One-clock pulse when the transfer ends |
| rdata | output | 16 | Assembled read data |
| rdy | input | 1 | Addressed device ready |
| hold | input | 1 | Another master requests the bus |
| hlda | output | 1 | Bus granted to the other master |
| ad_out | output | 16 | Multiplexed address/data, driven value |
| ad_in | input | 16 | Multiplexed address/data, received value |
| ad_oe | output | 1 | Enable for `ad_out` |
| a_hi_out | output | 4 | Upper address bits during T1, zero afterwards |
| bhe_n | output | 1 | Upper byte-lane enable, active low |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| mio | output | 1 | 1 = memory, 0 = I/O |
| bus_oe | output | 1 | Enable for the control and upper address outputs |

## Verification
The assertions assume the client keeps a request's fields steady from the moment `req_valid` rises until the edge where `req_ready` was high. They also assume `rdy` and `ad_in` are settled before every rising edge that samples them. The bench drives every input on the falling edge, so both conditions hold. It holds each request until it observes `req_ready`, and it derives `rdy` and `ad_in` from the strobes and the latched address it has seen. It never drives `rdy` low for more wait states than a test asks for.

// File: rtl/busseq_pkg.sv
package busseq_pkg;
   // Bus T-states; each lasts two clk periods (first half, second half).
   typedef enum logic [2:0] {
      TS_IDLE,
      TS_T1,
      TS_T2,
      TS_T3,
      TS_TW,
      TS_T4
   } tstate_e;
endpackage

// File: rtl/busseq_timing.sv
module busseq_timing
   import busseq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    go,
   input  logic    rdy,
   output tstate_e st,
   output logic    ph,
   output logic    dp,
   output logic    cap
);
   tstate_e nxt;

   always_comb begin
      unique case (st)
         TS_IDLE:      nxt = go ? TS_T1 : TS_IDLE;
         TS_T1:        nxt = TS_T2;
         TS_T2:        nxt = TS_T3;
         TS_T3, TS_TW: nxt = rdy ? TS_T4 : TS_TW;
         TS_T4:        nxt = go ? TS_T1 : TS_IDLE;
         default:      nxt = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= TS_IDLE;
         ph <= 1'b0;
      end else begin
         ph <= ~ph;
         if (ph) st <= nxt;
      end
   end

   // Midpoint of T4 or idle: the only place a cycle launches or the bus is granted.
   assign dp  = !ph && (st == TS_IDLE || st == TS_T4);
   // Ready sample point at the end of T3 or a wait state.
   assign cap = ph && (st == TS_T3 || st == TS_TW) && rdy;

   assert_t2_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_T2 && ph) |=> (st == TS_T3 && !ph));

   assert_wait_ins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph && (st == TS_T3 || st == TS_TW) && !rdy) |=> (st == TS_TW && !ph));
endmodule

// File: rtl/busseq_lanes.sv
module busseq_lanes #(
   parameter int DATA_W = 16
) (
   input  logic              word,
   input  logic              odd,
   input  logic              part,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ad_in,
   input  logic [7:0]        lo_hold,
   output logic [DATA_W-1:0] wbus,
   output logic [DATA_W-1:0] rd_word
);
   localparam int LANES = DATA_W / 8;

   logic       word_even;
   logic [7:0] wsel;

   assign word_even = word && !odd;
   // Second half of a split word carries the high byte.
   assign wsel      = (word && part) ? wdata[15:8] : wdata[7:0];

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      assign wbus[8*gl +: 8] = word_even ? wdata[8*gl +: 8] : wsel;
   end

   always_comb begin
      if (word_even)  rd_word = ad_in;
      else if (word)  rd_word = {ad_in[7:0], lo_hold};
      else if (odd)   rd_word = {8'h00, ad_in[15:8]};
      else            rd_word = {8'h00, ad_in[7:0]};
   end
endmodule

// File: rtl/busseq_ctrl.sv
module busseq_ctrl #(
   parameter int ADDR_W    = 20,
   parameter int IO_ADDR_W = 16,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dp,
   input  logic              ph,
   input  logic              cap,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_mem,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              hold,
   input  logic [DATA_W-1:0] ad_in,
   input  logic [DATA_W-1:0] rd_word,
   output logic              req_ready,
   output logic              go,
   output logic              hlda,
   output logic              ctl_oe,
   output logic              cur_wr,
   output logic              cur_mem,
   output logic              cur_word,
   output logic              cur_odd,
   output logic              cur_part,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_bhe_n,
   output logic [DATA_W-1:0] wdata_q,
   output logic [7:0]        lo_hold,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   logic split;
   logic first_of_split;

   function automatic logic [ADDR_W-1:0] fit(input logic [ADDR_W-1:0] a, input logic m);
      logic [ADDR_W-1:0] r;
      r = a;
      if (!m) r[ADDR_W-1:IO_ADDR_W] = '0;
      return r;
   endfunction

   assign req_ready      = dp && !hlda && !hold && !split;
   assign first_of_split = cur_word && cur_odd && !cur_part;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go        <= 1'b0;
         hlda      <= 1'b0;
         ctl_oe    <= 1'b0;
         split     <= 1'b0;
         cur_wr    <= 1'b0;
         cur_mem   <= 1'b0;
         cur_word  <= 1'b0;
         cur_odd   <= 1'b0;
         cur_part  <= 1'b0;
         cur_addr  <= '0;
         cur_bhe_n <= 1'b1;
         wdata_q   <= '0;
         lo_hold   <= '0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         done <= 1'b0;
         if (ph) go <= 1'b0;
         if (hlda && !hold) hlda <= 1'b0;
         if (dp && !hlda) begin
            if (hold) begin
               hlda   <= 1'b1;
               ctl_oe <= 1'b0;
            end else if (split) begin
               split     <= 1'b0;
               cur_part  <= 1'b1;
               cur_addr  <= fit(cur_addr + 1'b1, cur_mem);
               cur_bhe_n <= 1'b1;
               ctl_oe    <= 1'b1;
               go        <= 1'b1;
            end else if (req_valid) begin
               cur_wr    <= req_write;
               cur_mem   <= req_mem;
               cur_word  <= req_word;
               cur_odd   <= req_addr[0];
               cur_part  <= 1'b0;
               split     <= req_word && req_addr[0];
               cur_addr  <= fit(req_addr, req_mem);
               cur_bhe_n <= !(req_word || req_addr[0]);
               wdata_q   <= req_wdata;
               ctl_oe    <= 1'b1;
               go        <= 1'b1;
            end
         end
         if (cap) begin
            if (first_of_split) begin
               lo_hold <= ad_in[15:8];
            end else begin
               done <= 1'b1;
               if (!cur_wr) rdata <= rd_word;
            end
         end
      end
   end

   assert_hlda_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda) |-> $past(dp));

   assert_hlda_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> !ctl_oe);

   assert_hlda_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!req_ready && !go));

   assert_split_one_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && first_of_split) |=> !done);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import busseq_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int IO_ADDR_W = 16,
   parameter int DATA_W    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic                     req_mem,
   input  logic                     req_word,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     done,
   output logic [DATA_W-1:0]        rdata,
   input  logic                     rdy,
   input  logic                     hold,
   output logic                     hlda,
   output logic [DATA_W-1:0]        ad_out,
   input  logic [DATA_W-1:0]        ad_in,
   output logic                     ad_oe,
   output logic [ADDR_W-DATA_W-1:0] a_hi_out,
   output logic                     bhe_n,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     den_n,
   output logic                     dtr,
   output logic                     mio,
   output logic                     bus_oe
);
   localparam int HI_W = ADDR_W - DATA_W;

   if (DATA_W != 16) begin : g_bad_data_w
      $error("bus_cycle_seq: DATA_W must be 16 (two byte lanes)");
   end
   if (HI_W < 1) begin : g_bad_addr_w
      $error("bus_cycle_seq: ADDR_W must exceed DATA_W");
   end
   if (IO_ADDR_W > DATA_W || IO_ADDR_W < 1) begin : g_bad_io_w
      $error("bus_cycle_seq: IO_ADDR_W must be 1..DATA_W");
   end

   tstate_e           st;
   logic              ph, dp, cap, go, ctl_oe;
   logic              cur_wr, cur_mem, cur_word, cur_odd, cur_part, cur_bhe_n;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] wdata_q, wbus, rd_word;
   logic [7:0]        lo_hold;
   logic              strobe;

   busseq_timing i_timing (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .rdy   (rdy),
      .st    (st),
      .ph    (ph),
      .dp    (dp),
      .cap   (cap)
   );

   busseq_ctrl #(.ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .DATA_W(DATA_W)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .dp        (dp),
      .ph        (ph),
      .cap       (cap),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_mem   (req_mem),
      .req_word  (req_word),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .hold      (hold),
      .ad_in     (ad_in),
      .rd_word   (rd_word),
      .req_ready (req_ready),
      .go        (go),
      .hlda      (hlda),
      .ctl_oe    (ctl_oe),
      .cur_wr    (cur_wr),
      .cur_mem   (cur_mem),
      .cur_word  (cur_word),
      .cur_odd   (cur_odd),
      .cur_part  (cur_part),
      .cur_addr  (cur_addr),
      .cur_bhe_n (cur_bhe_n),
      .wdata_q   (wdata_q),
      .lo_hold   (lo_hold),
      .done      (done),
      .rdata     (rdata)
   );

   busseq_lanes #(.DATA_W(DATA_W)) i_lanes (
      .word    (cur_word),
      .odd     (cur_odd),
      .part    (cur_part),
      .wdata   (wdata_q),
      .ad_in   (ad_in),
      .lo_hold (lo_hold),
      .wbus    (wbus),
      .rd_word (rd_word)
   );

   assign strobe   = (st == TS_T2) || (st == TS_T3) || (st == TS_TW);
   assign ale      = (st == TS_T1);
   assign rd_n     = !(strobe && !cur_wr);
   assign wr_n     = !(strobe && cur_wr);
   assign den_n    = !(((st == TS_T2) && (cur_wr || ph)) || (st == TS_T3) ||
                       (st == TS_TW) || ((st == TS_T4) && !ph));
   assign ad_oe    = ctl_oe && ((st == TS_T1) || (cur_wr && (strobe || st == TS_T4)));
   assign ad_out   = (st == TS_T1) ? cur_addr[DATA_W-1:0] : wbus;
   assign a_hi_out = (st == TS_T1) ? cur_addr[ADDR_W-1:DATA_W] : '0;
   assign bhe_n    = cur_bhe_n;
   assign mio      = cur_mem;
   assign dtr      = cur_wr;
   assign bus_oe   = ctl_oe;

   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   assert_ale_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n && den_n));

   assert_io_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ale && !mio) |-> (a_hi_out == '0));

   assert_dir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> ($stable(mio) && $stable(dtr)));

   assert_den_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !den_n);

   assert_den_read_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> den_n);
endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b1, req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rdy = 1'b1, hold = 1'b0;
   logic [15:0] ad_in = '0;
   logic        req_ready, done, hlda, ad_oe, bhe_n, ale, rd_n, wr_n, den_n, dtr, mio, bus_oe;
   logic [15:0] rdata, ad_out;
   logic [3:0]  a_hi_out;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   bus_cycle_seq i_bus_cycle_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_mem(req_mem), .req_word(req_word),
      .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
      .rdy(rdy), .hold(hold), .hlda(hlda), .ad_out(ad_out), .ad_in(ad_in),
      .ad_oe(ad_oe), .a_hi_out(a_hi_out), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n),
      .wr_n(wr_n), .den_n(den_n), .dtr(dtr), .mio(mio), .bus_oe(bus_oe));

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] mb(input logic [19:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], a[19:16]} ^ 8'h3C;
   endfunction

   function automatic logic [19:0] fit(input logic [19:0] a, input logic m);
      return m ? a : {4'h0, a[15:0]};
   endfunction

   // Runs one transfer, acting as the addressed device, and checks it.
   task automatic do_xfer(input logic wr, input logic mem, input logic word,
                          input logic [19:0] addr, input logic [15:0] wd,
                          input int waits, input bit hold_mid);
      int parts, pi, k, ale_c, rd_c, wr_c, den_c, span, oe_bad, dir_bad, hl_bad, it;
      bit accepted, seen_done, prev_ale, in_span, prev_mio, prev_dtr, wr_seen;
      logic [19:0] a_seen [2];
      logic        b_seen [2];
      logic [15:0] w_seen [2];
      logic [19:0] ae, exp_a;
      logic [15:0] exp_w, exp_r;
      parts = (word && addr[0]) ? 2 : 1;
      pi = 0; k = 0; ale_c = 0; rd_c = 0; wr_c = 0; den_c = 0; span = 0;
      oe_bad = 0; dir_bad = 0; hl_bad = 0; seen_done = 0; in_span = 0; wr_seen = 0;
      a_seen[0] = '0; a_seen[1] = '0; b_seen[0] = 1'b1; b_seen[1] = 1'b1;
      w_seen[0] = '0; w_seen[1] = '0;
      req_write = wr; req_mem = mem; req_word = word; req_addr = addr; req_wdata = wd;
      req_valid = 1'b1;
      #1;
      accepted = req_ready;
      prev_ale = ale; prev_mio = mio; prev_dtr = dtr;
      for (it = 0; it < 400 && !seen_done; it++) begin
         @(negedge clk);
         if (accepted) req_valid = 1'b0;
         if (ale) begin
            if (!prev_ale) begin
               pi++;
               wr_seen = 0;
               if (pi <= 2) begin
                  a_seen[pi-1] = {a_hi_out, ad_out};
                  b_seen[pi-1] = bhe_n;
               end
               // R6: new direction/space already valid one clock before T1
               if (prev_mio !== mem || prev_dtr !== wr) dir_bad++;
               in_span = 1;
            end
            ale_c++;
            if (!ad_oe) oe_bad++;
         end
         if (in_span) span++;
         if (mio !== mem || dtr !== wr) if (in_span) dir_bad++;
         if (!rd_n) begin rd_c++; if (ad_oe) oe_bad++; end
         if (!wr_n) begin
            wr_c++;
            if (!ad_oe) oe_bad++;
            if (!wr_seen && pi >= 1 && pi <= 2) begin w_seen[pi-1] = ad_out; wr_seen = 1; end
         end
         if (!den_n) den_c++;
         if (hold_mid && !rd_n) hold = 1'b1;
         if (hold_mid && !wr_n) hold = 1'b1;
         if (hlda) hl_bad++;
         if (!rd_n || !wr_n) k++; else k = 0;
         rdy = (k >= 2*waits + 4);
         ae = {a_seen[(pi > 0) ? pi-1 : 0][19:1], 1'b0};
         ad_in = {mb(ae | 20'h1), mb(ae)};
         if (done) seen_done = 1;
         accepted = req_valid && req_ready;
         prev_ale = ale; prev_mio = mio; prev_dtr = dtr;
      end
      rdy = 1'b1;
      chk(seen_done, "R12 done pulse seen", seen_done, 1);
      chk(pi == parts, "R10 bus cycle count", pi, parts);
      chk(ale_c == 2*parts, "R2 ale clocks", ale_c, 2*parts);
      if (parts == 1) chk(span == 7 + 2*waits, "R1 T1-to-done span", span, 7 + 2*waits);
      if (wr) chk(wr_c == parts*(4 + 2*waits) && rd_c == 0, "R4 wr_n low clocks", wr_c, parts*(4+2*waits));
      else    chk(rd_c == parts*(4 + 2*waits) && wr_c == 0, "R4 rd_n low clocks", rd_c, parts*(4+2*waits));
      if (waits > 0) chk((wr ? wr_c : rd_c) == parts*(4 + 2*waits), "R3 wait states added",
                         wr ? wr_c : rd_c, parts*(4+2*waits));
      chk(den_c == parts*((wr ? 5 : 4) + 2*waits), "R5 den_n low clocks", den_c,
          parts*((wr ? 5 : 4) + 2*waits));
      chk(dir_bad == 0, "R6 mio/dtr timing", dir_bad, 0);
      chk(oe_bad == 0, "R13 ad_oe per phase", oe_bad, 0);
      if (hold_mid) chk(hl_bad == 0, "R9 no grant inside cycle", hl_bad, 0);
      exp_a = fit(addr, mem);
      chk(a_seen[0] == exp_a, mem ? "R7 T1 address" : "R8 io address upper zero", a_seen[0], exp_a);
      chk(b_seen[0] == !(word || addr[0]), "R7 bhe_n", b_seen[0], !(word || addr[0]));
      if (parts == 2) begin
         chk(a_seen[1] == fit(addr + 20'h1, mem), "R10 second address", a_seen[1], fit(addr + 20'h1, mem));
         chk(b_seen[1] == 1'b1, "R10 second bhe_n", b_seen[1], 1);
      end
      if (wr) begin
         if (parts == 2) begin
            chk(w_seen[0] == {wd[7:0], wd[7:0]}, "R10 first write lane", w_seen[0], {wd[7:0], wd[7:0]});
            chk(w_seen[1] == {wd[15:8], wd[15:8]}, "R10 second write lane", w_seen[1], {wd[15:8], wd[15:8]});
         end else begin
            exp_w = word ? wd : {wd[7:0], wd[7:0]};
            chk(w_seen[0] == exp_w, "R13 write lanes", w_seen[0], exp_w);
         end
      end else begin
         exp_r = word ? {mb(fit(addr + 20'h1, mem)), mb(exp_a)} : {8'h00, mb(exp_a)};
         chk(rdata == exp_r, parts == 2 ? "R10 odd word read data" : "R12 read data", rdata, exp_r);
      end
   endtask

   task automatic t_reset;
      chk(!ale && !hlda && !ad_oe && !bus_oe && !done && rd_n && wr_n, "R11 outputs in reset",
          {ale, hlda, ad_oe, bus_oe, done, rd_n, wr_n}, 7'b0000011);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!ale && !hlda && !ad_oe && !bus_oe && !done && rd_n && wr_n, "R11 outputs after reset",
          {ale, hlda, ad_oe, bus_oe, done, rd_n, wr_n}, 7'b0000011);
   endtask

   task automatic t_reads_basic;
      do_xfer(1'b0, 1'b1, 1'b1, 20'h4A2B6, 16'h0, 0, 0);   // R12 even word
      do_xfer(1'b0, 1'b1, 1'b0, 20'h13570, 16'h0, 0, 0);   // R7 even byte, lower lane
      do_xfer(1'b0, 1'b1, 1'b0, 20'h13571, 16'h0, 0, 0);   // R7 odd byte, upper lane
   endtask

   task automatic t_waits;
      do_xfer(1'b0, 1'b1, 1'b1, 20'hC0DE0, 16'h0, 2, 0);   // R3 read with two waits
      do_xfer(1'b1, 1'b1, 1'b1, 20'h00402, 16'hBEEF, 1, 0); // R3 write with one wait
   endtask

   task automatic t_writes;
      do_xfer(1'b1, 1'b1, 1'b1, 20'h2F00E, 16'h1234, 0, 0); // R13 word
      do_xfer(1'b1, 1'b1, 1'b0, 20'h2F00F, 16'h99A5, 0, 0); // R13 odd byte
   endtask

   task automatic t_odd_word;
      do_xfer(1'b0, 1'b1, 1'b1, 20'h7FFF3, 16'h0, 1, 0);    // R10 read split
      do_xfer(1'b1, 1'b1, 1'b1, 20'h08001, 16'hC3E1, 0, 0); // R10 write split
   endtask

   task automatic t_io;
      do_xfer(1'b0, 1'b0, 1'b1, 20'hA1234, 16'h0, 0, 0);    // R8 io read, upper bits dropped
      do_xfer(1'b1, 1'b0, 1'b0, 20'h5FF81, 16'h0077, 0, 0); // R8 io byte write
      do_xfer(1'b0, 1'b1, 1'b0, 20'hE0010, 16'h0, 0, 0);    // R6 switch back to memory
   endtask

   task automatic t_hold_idle;
      int got;
      repeat (3) @(negedge clk);
      hold = 1'b1;
      got = -1;
      for (int i = 0; i < 3 && got < 0; i++) begin
         @(negedge clk);
         if (hlda) got = i;
      end
      chk(got >= 0 && got <= 1, "R9 grant within one idle state", got, 1);
      chk(!ad_oe && !bus_oe, "R9 outputs released", {ad_oe, bus_oe}, 0);
      req_valid = 1'b1; req_write = 1'b0; req_mem = 1'b1; req_word = 1'b1; req_addr = 20'h00100;
      for (int i = 0; i < 6; i++) begin
         #1;
         chk(!req_ready && !ale && hlda, "R9 no cycle while granted", {req_ready, ale, hlda}, 3'b001);
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(!ale && !ad_oe && !bus_oe, "R2 ale low while granted", {ale, ad_oe, bus_oe}, 0);
      hold = 1'b0;
      @(negedge clk);
      chk(!hlda, "R9 hlda falls after hold low", hlda, 0);
      do_xfer(1'b0, 1'b1, 1'b1, 20'h00100, 16'h0, 0, 0);
   endtask

   task automatic t_hold_mid;
      do_xfer(1'b1, 1'b1, 1'b1, 20'h3C3C0, 16'h5AA5, 1, 1);
      @(negedge clk);
      chk(hlda && !ad_oe && !bus_oe, "R9 grant at middle of T4", {hlda, ad_oe, bus_oe}, 3'b100);
      hold = 1'b0;
      @(negedge clk);
      chk(!hlda, "R9 release after hold low", hlda, 0);
      do_xfer(1'b0, 1'b1, 1'b0, 20'h3C3C1, 16'h0, 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_reads_basic();
      t_waits();
      t_writes();
      t_odd_word();
      t_io();
      t_hold_idle();
      t_hold_mid();
      repeat (4) @(negedge clk);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule